// File: doc/BRIEF.md
# Autonegotiation Advertisement and Restart Sequencer

This block turns a requested speed/duplex mask and a flow-control mode into the advertisement words of an Ethernet PHY, writes them back by read-modify-write through a generic register-access port, restarts autonegotiation and then polls the PHY status register until negotiation completes or a bounded number of polls has run out. It sits between a management controller and a register-access engine. The MDIO frame engine is not part of this block, and neither is link-partner resolution.

A single `start` pulse launches one sequence. The block latches the masks and the mode, and the inputs may change once `busy` is high. The access port carries a device field, where 0 selects a clause-22 register and 7 selects the autonegotiation MMD. It also carries a 16-bit register number. A request stays asserted until the engine returns a one-cycle `acc_ack`, which may carry `acc_err`. The block ends each sequence with a one-cycle `done` and a held `status`.

States: S_IDLE, S_RD_ADV, S_RD_GIG, S_RD_MG, S_WR_ADV, S_WR_GIG, S_WR_MG, S_RD_CTL, S_WR_CTL, S_RD_ST1, S_RD_ST2, S_WAIT, S_FINISH. Transitions:
- S_IDLE goes to S_FINISH on `start` with a bad mode, or to S_RD_ADV on a good one.
- After the advertisement read, the optional gigabit read and the optional 2.5G read follow, each only if the capability mask allows that speed. The writes follow in the same order.
- S_RD_CTL and S_WR_CTL come next, then S_RD_ST1 and S_RD_ST2.
- S_RD_ST2 goes to S_FINISH when completion is seen or the last poll is used. Otherwise it goes to S_WAIT.
- S_WAIT returns to S_RD_ST1 after the poll interval.
- An acknowledged error in any access state goes to S_FINISH.
- S_FINISH returns to S_IDLE.

Top module: `an_adv_seq`

## Requirements
- R1: After reset `busy`, `done`, `acc_req`, `an_complete` are 0 and `status` is 2'b00 (ok; 2'b01 = configuration error, 2'b10 = access error).
- R2: Mask bits 0..3 (10 half, 10 full, 100 half, 100 full) set register 4 bits 5..8 in that order; those four bits are cleared before being set, other bits of register 4 except 10/11 are kept.
- R3: Mask bit 5 (1000 full) sets register 9 bit 9 and bit 8 is always cleared; mask bit 4 (1000 half) is never advertised.
- R4: Mask bit 7 (2.5G full) sets bit 7 of device 7 register 32 and clears it when absent; mask bit 6 (2.5G half) is never advertised.
- R5: The advertised mask is `adv_req & cap_mask`; if that is zero, `cap_mask` is advertised.
- R6: Flow-control mode 0 (none) clears register 4 bits 10 and 11; modes 1 (receive) and 3 (both) set both; mode 2 (transmit) sets bit 11 and clears bit 10.
- R7: A mode value 4..7 ends the sequence with status 2'b01 and no register access.
- R8: Register 9 is accessed only when `cap_mask[5]` is set, and device 7 register 32 only when `cap_mask[7]` is set.
- R9: Register 0 is rewritten with bits 12 and 9 set and every other bit preserved.
- R10: Each poll reads register 1 twice (device 0) and never writes it; bit 5 of the second read ends the sequence with status ok and `an_complete` = 1.
- R11: After POLL_LIMIT polls without completion the sequence ends with status ok and `an_complete` = 0; polls are spaced by TICKS_PER_POLL `poll_tick` pulses.
- R12: An access acknowledged with `acc_err` aborts the sequence with status 2'b10 and no further access.
- R13: `acc_req` with its address, direction and write data holds steady until `acc_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle launch of a sequence |
| adv_req | input | 8 | Requested speed/duplex mask |
| cap_mask | input | 8 | Speeds the port is allowed to advertise |
| fc_mode | input | 3 | Flow-control mode 0..3, others invalid |
| poll_tick | input | 1 | Prescaled time tick for poll spacing |
| acc_req | output | 1 | Register access request |
| acc_wr | output | 1 | 1 = write, 0 = read |
| acc_dev | output | 5 | 0 = clause-22 register, 7 = autonegotiation MMD |
| acc_reg | output | 16 | Register number |
| acc_wdata | output | 16 | Write data |
| acc_ack | input | 1 | One-cycle access completion |
| acc_err | input | 1 | Access failed, valid with `acc_ack` |
| acc_rdata | input | 16 | Read data, valid with `acc_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end of sequence |
| status | output | 2 | Result code of the last sequence |
| an_complete | output | 1 | Completion bit was seen in the last sequence |

## Verification
The bench builds the block with POLL_LIMIT = 4 and TICKS_PER_POLL = 2, and it holds `poll_tick` high. With these values the poll-exhaustion path takes a few dozen cycles instead of 45 intervals of 100 ms, so the bench can count the exact number of status reads on a timeout. A behavioural register model answers every access after two cycles, presets each register and counts accesses by address. With it the bench checks the exact words written, shows that gated registers are never touched, and confirms that an injected error on the third access stops all further traffic.

// File: rtl/an_seq_pkg.sv
package an_seq_pkg;
    localparam int MASK_W = 8;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_ADV, S_RD_GIG, S_RD_MG, S_WR_ADV, S_WR_GIG, S_WR_MG,
        S_RD_CTL, S_WR_CTL, S_RD_ST1, S_RD_ST2, S_WAIT, S_FINISH
    } an_state_e;

    typedef enum logic [1:0] {
        ST_OK  = 2'b00,
        ST_CFG = 2'b01,
        ST_ACC = 2'b10
    } an_status_e;

    localparam logic [4:0]  DEV_C22  = 5'd0;
    localparam logic [4:0]  DEV_AN   = 5'd7;
    localparam logic [15:0] REG_CTL  = 16'd0;
    localparam logic [15:0] REG_STAT = 16'd1;
    localparam logic [15:0] REG_ADV  = 16'd4;
    localparam logic [15:0] REG_GIG  = 16'd9;
    localparam logic [15:0] REG_MG   = 16'd32;

    localparam int BIT_GIG_FULL = 5;
    localparam int BIT_MG_FULL  = 7;
    localparam int BIT_AN_DONE  = 5;

    function automatic logic fc_mode_ok(input logic [2:0] m);
        return (m[2] == 1'b0);
    endfunction
endpackage

// File: rtl/an_adv_map.sv
module an_adv_map
    import an_seq_pkg::*;
(
    input  logic [MASK_W-1:0] eff,
    input  logic [1:0]        fc,
    input  logic [15:0]       adv_rd,
    input  logic [15:0]       gig_rd,
    input  logic [15:0]       mg_rd,
    output logic [15:0]       adv_wr,
    output logic [15:0]       gig_wr,
    output logic [15:0]       mg_wr
);
    localparam int LEGACY_N    = 4;
    localparam int LEGACY_BASE = 5;

    always_comb begin
        adv_wr = adv_rd & ~16'h0DE0;
        for (int i = 0; i < LEGACY_N; i++) begin
            adv_wr[LEGACY_BASE + i] = eff[i];
        end
        unique case (fc)
            2'd0:    adv_wr[11:10] = 2'b00;
            2'd2:    adv_wr[11:10] = 2'b10;
            default: adv_wr[11:10] = 2'b11;
        endcase

        gig_wr    = gig_rd & ~16'h0300;
        gig_wr[9] = eff[BIT_GIG_FULL];

        mg_wr    = mg_rd;
        mg_wr[7] = eff[BIT_MG_FULL];
    end
endmodule

// File: rtl/an_poll_timer.sv
module an_poll_timer #(
    parameter int POLL_LIMIT     = 45,
    parameter int TICKS_PER_POLL = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic poll_miss,
    input  logic waiting,
    input  logic tick,
    output logic last_poll,
    output logic interval_up
);
    localparam int PW = $clog2(POLL_LIMIT + 1);
    localparam int TW = $clog2(TICKS_PER_POLL + 1);

    logic [PW-1:0] polls;
    logic [TW-1:0] ticks;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            polls <= '0;
        end else if (poll_miss) begin
            polls <= polls + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !waiting) begin
            ticks <= '0;
        end else if (tick) begin
            ticks <= ticks + 1'b1;
        end
    end

    assign last_poll   = (polls == PW'(POLL_LIMIT - 1));
    assign interval_up = waiting && tick && (ticks == TW'(TICKS_PER_POLL - 1));
endmodule

// File: rtl/an_adv_seq.sv
module an_adv_seq
    import an_seq_pkg::*;
#(
    parameter int POLL_LIMIT     = 45,
    parameter int TICKS_PER_POLL = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [7:0]  adv_req,
    input  logic [7:0]  cap_mask,
    input  logic [2:0]  fc_mode,
    input  logic        poll_tick,
    output logic        acc_req,
    output logic        acc_wr,
    output logic [4:0]  acc_dev,
    output logic [15:0] acc_reg,
    output logic [15:0] acc_wdata,
    input  logic        acc_ack,
    input  logic        acc_err,
    input  logic [15:0] acc_rdata,
    output logic        busy,
    output logic        done,
    output logic [1:0]  status,
    output logic        an_complete
);
    an_state_e          state, nxt;
    logic [MASK_W-1:0]  cap_q, eff_q, masked;
    logic [1:0]         fc_q;
    logic [15:0]        adv_rd, gig_rd, mg_rd, ctl_rd;
    logic [15:0]        adv_wr, gig_wr, mg_wr;
    an_status_e         status_q;
    logic               done_seen;
    logic               ok_ack, seen_done_bit, last_poll, interval_up, poll_miss;

    assign masked        = adv_req & cap_mask;
    assign ok_ack        = acc_ack && !acc_err;
    assign seen_done_bit = acc_rdata[BIT_AN_DONE];
    assign poll_miss     = (state == S_RD_ST2) && ok_ack && !seen_done_bit;

    an_adv_map u_map (
        .eff(eff_q), .fc(fc_q), .adv_rd(adv_rd), .gig_rd(gig_rd), .mg_rd(mg_rd),
        .adv_wr(adv_wr), .gig_wr(gig_wr), .mg_wr(mg_wr)
    );

    an_poll_timer #(.POLL_LIMIT(POLL_LIMIT), .TICKS_PER_POLL(TICKS_PER_POLL)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clear(state == S_IDLE), .poll_miss(poll_miss),
        .waiting(state == S_WAIT), .tick(poll_tick),
        .last_poll(last_poll), .interval_up(interval_up)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (acc_req && acc_ack && acc_err) begin
            nxt = S_FINISH;
        end else begin
            unique case (state)
                S_IDLE:   if (start) nxt = fc_mode_ok(fc_mode) ? S_RD_ADV : S_FINISH;
                S_RD_ADV: if (acc_ack) nxt = cap_q[BIT_GIG_FULL] ? S_RD_GIG :
                                             cap_q[BIT_MG_FULL]  ? S_RD_MG : S_WR_ADV;
                S_RD_GIG: if (acc_ack) nxt = cap_q[BIT_MG_FULL] ? S_RD_MG : S_WR_ADV;
                S_RD_MG:  if (acc_ack) nxt = S_WR_ADV;
                S_WR_ADV: if (acc_ack) nxt = cap_q[BIT_GIG_FULL] ? S_WR_GIG :
                                             cap_q[BIT_MG_FULL]  ? S_WR_MG : S_RD_CTL;
                S_WR_GIG: if (acc_ack) nxt = cap_q[BIT_MG_FULL] ? S_WR_MG : S_RD_CTL;
                S_WR_MG:  if (acc_ack) nxt = S_RD_CTL;
                S_RD_CTL: if (acc_ack) nxt = S_WR_CTL;
                S_WR_CTL: if (acc_ack) nxt = S_RD_ST1;
                S_RD_ST1: if (acc_ack) nxt = S_RD_ST2;
                S_RD_ST2: if (acc_ack) nxt = (seen_done_bit || last_poll) ? S_FINISH : S_WAIT;
                S_WAIT:   if (interval_up) nxt = S_RD_ST1;
                S_FINISH: nxt = S_IDLE;
                default:  nxt = S_IDLE;
            endcase
        end
    end

    // Latched request, read-back words and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q     <= '0;
            eff_q     <= '0;
            fc_q      <= '0;
            adv_rd    <= '0;
            gig_rd    <= '0;
            mg_rd     <= '0;
            ctl_rd    <= '0;
            status_q  <= ST_OK;
            done_seen <= 1'b0;
        end else begin
            if (state == S_IDLE && start) begin
                cap_q     <= cap_mask;
                eff_q     <= (masked == '0) ? cap_mask : masked;
                fc_q      <= fc_mode[1:0];
                status_q  <= fc_mode_ok(fc_mode) ? ST_OK : ST_CFG;
                done_seen <= 1'b0;
            end
            if (acc_req && acc_ack && acc_err) status_q <= ST_ACC;
            if (ok_ack) begin
                unique case (state)
                    S_RD_ADV: adv_rd <= acc_rdata;
                    S_RD_GIG: gig_rd <= acc_rdata;
                    S_RD_MG:  mg_rd  <= acc_rdata;
                    S_RD_CTL: ctl_rd <= acc_rdata;
                    S_RD_ST2: done_seen <= seen_done_bit;
                    default:  ;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        acc_req   = 1'b1;
        acc_wr    = 1'b0;
        acc_dev   = DEV_C22;
        acc_reg   = REG_STAT;
        acc_wdata = '0;
        unique case (state)
            S_RD_ADV: acc_reg = REG_ADV;
            S_RD_GIG: acc_reg = REG_GIG;
            S_RD_MG:  begin acc_dev = DEV_AN; acc_reg = REG_MG; end
            S_WR_ADV: begin acc_wr = 1'b1; acc_reg = REG_ADV; acc_wdata = adv_wr; end
            S_WR_GIG: begin acc_wr = 1'b1; acc_reg = REG_GIG; acc_wdata = gig_wr; end
            S_WR_MG:  begin acc_wr = 1'b1; acc_dev = DEV_AN; acc_reg = REG_MG; acc_wdata = mg_wr; end
            S_RD_CTL: acc_reg = REG_CTL;
            S_WR_CTL: begin acc_wr = 1'b1; acc_reg = REG_CTL; acc_wdata = ctl_rd | 16'h1200; end
            S_RD_ST1, S_RD_ST2: acc_reg = REG_STAT;
            default:  acc_req = 1'b0;
        endcase
        busy        = (state != S_IDLE);
        done        = (state == S_FINISH);
        status      = status_q;
        an_complete = done_seen;
    end
endmodule

// File: rtl/an_adv_seq_chk.sv
module an_adv_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  cap_mask,
    input logic        acc_req,
    input logic        acc_wr,
    input logic [4:0]  acc_dev,
    input logic [15:0] acc_reg,
    input logic [15:0] acc_wdata,
    input logic        acc_ack,
    input logic        acc_err,
    input logic        busy,
    input logic        done
);
    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !acc_ack |=> acc_req && $stable(acc_wr) && $stable(acc_dev)
                                && $stable(acc_reg) && $stable(acc_wdata));

    p_err_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_ack && acc_err |=> !acc_req ##1 !acc_req);

    p_gig_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_dev == 5'd0 && acc_reg == 16'd9 |-> cap_mask[5]);

    p_mg_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_dev == 5'd7 |-> cap_mask[7]);

    p_ctl_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_wr && acc_dev == 5'd0 && acc_reg == 16'd0 |-> acc_wdata[12] && acc_wdata[9]);

    p_stat_read_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && acc_dev == 5'd0 && acc_reg == 16'd1 |-> !acc_wr);

    p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy && !acc_req);
endmodule

bind an_adv_seq an_adv_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cap_mask(cap_mask), .acc_req(acc_req), .acc_wr(acc_wr),
    .acc_dev(acc_dev), .acc_reg(acc_reg), .acc_wdata(acc_wdata), .acc_ack(acc_ack),
    .acc_err(acc_err), .busy(busy), .done(done)
);

// File: tb/an_adv_seq_tb.sv
`timescale 1ns/1ps
module an_adv_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  adv_req = '0, cap_mask = '0;
    logic [2:0]  fc_mode = '0;
    logic        poll_tick = 1'b1;
    logic        acc_req, acc_wr, acc_ack = 1'b0, acc_err = 1'b0;
    logic [4:0]  acc_dev;
    logic [15:0] acc_reg, acc_wdata, acc_rdata = '0;
    logic        busy, done, an_complete;
    logic [1:0]  status;

    int checks = 0, fails = 0, cycles = 0;

    // register model state
    logic [15:0] m_r0, m_r4, m_r9, m_m32;
    logic [15:0] p_r0, p_r4, p_r9, p_m32;
    int n_acc, n_r1, n_r9, n_m32, lat;
    int err_idx = -1, complete_after = 2;
    logic prep = 1'b0;

    always #4 clk = ~clk;

    an_adv_seq #(.POLL_LIMIT(4), .TICKS_PER_POLL(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .adv_req(adv_req), .cap_mask(cap_mask),
        .fc_mode(fc_mode), .poll_tick(poll_tick), .acc_req(acc_req), .acc_wr(acc_wr),
        .acc_dev(acc_dev), .acc_reg(acc_reg), .acc_wdata(acc_wdata), .acc_ack(acc_ack),
        .acc_err(acc_err), .acc_rdata(acc_rdata), .busy(busy), .done(done),
        .status(status), .an_complete(an_complete)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (prep) begin
            m_r0 <= p_r0; m_r4 <= p_r4; m_r9 <= p_r9; m_m32 <= p_m32;
            n_acc <= 0; n_r1 <= 0; n_r9 <= 0; n_m32 <= 0; lat <= 0;
            acc_ack <= 1'b0; acc_err <= 1'b0;
        end else if (acc_ack) begin
            acc_ack <= 1'b0;
            acc_err <= 1'b0;
        end else if (acc_req) begin
            if (lat == 1) begin
                lat     <= 0;
                acc_ack <= 1'b1;
                n_acc   <= n_acc + 1;
                if (acc_dev == 5'd0 && acc_reg == 16'd9) n_r9 <= n_r9 + 1;
                if (acc_dev == 5'd7) n_m32 <= n_m32 + 1;
                if (n_acc == err_idx) begin
                    acc_err <= 1'b1;
                end else if (acc_wr) begin
                    if (acc_dev == 5'd7 && acc_reg == 16'd32) m_m32 <= acc_wdata;
                    else if (acc_reg == 16'd0) m_r0 <= acc_wdata;
                    else if (acc_reg == 16'd4) m_r4 <= acc_wdata;
                    else if (acc_reg == 16'd9) m_r9 <= acc_wdata;
                end else begin
                    if (acc_dev == 5'd7) acc_rdata <= m_m32;
                    else if (acc_reg == 16'd0) acc_rdata <= m_r0;
                    else if (acc_reg == 16'd4) acc_rdata <= m_r4;
                    else if (acc_reg == 16'd9) acc_rdata <= m_r9;
                    else if (acc_reg == 16'd1) begin
                        n_r1 <= n_r1 + 1;
                        acc_rdata <= (n_r1 + 1 >= complete_after) ? 16'h0020 : 16'h0000;
                    end else acc_rdata <= 16'h0000;
                end
            end else begin
                lat <= lat + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic setup(input logic [15:0] r0, r4, r9, m32, input int eidx, input int cafter);
        @(negedge clk);
        p_r0 = r0; p_r4 = r4; p_r9 = r9; p_m32 = m32;
        err_idx = eidx; complete_after = cafter;
        prep = 1'b1;
        @(negedge clk);
        prep = 1'b0;
    endtask

    task automatic run(input logic [7:0] req, cap, input logic [2:0] fc);
        int wait_n;
        adv_req = req; cap_mask = cap; fc_mode = fc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_n = 0;
        while (!done && wait_n < 2000) begin
            @(negedge clk);
            wait_n++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: sequence never finished, actual 0 expected 1");
            finish_run();
        end
    endtask

    task automatic t_reset();
        check(!busy && !done && !acc_req, "R1 idle outputs", {busy, done, acc_req}, 0);
        check(status == 2'b00 && !an_complete, "R1 status", {status, an_complete}, 0);
    endtask

    task automatic t_legacy_full_fc();
        setup(16'h0140, 16'h0161, 16'h0301, 16'h0081, -1, 2);
        run(8'h05, 8'hFF, 3'd3);
        check(m_r4 == 16'h0CA1, "R2 R6 reg4 10H/100H both-pause", m_r4, 16'h0CA1);
        check(m_r9 == 16'h0001, "R3 reg9 cleared", m_r9, 16'h0001);
        check(m_m32 == 16'h0001, "R4 mmd bit7 cleared", m_m32, 16'h0001);
        check(m_r0 == 16'h1340, "R9 ctl restart bits", m_r0, 16'h1340);
        check(status == 2'b00 && an_complete, "R10 completed", {status, an_complete}, 1);
        check(n_r1 == 2, "R10 two status reads per poll", n_r1, 2);
    endtask

    task automatic t_half_refused();
        setup(16'h0000, 16'h0400, 16'h0000, 16'h0000, -1, 2);
        run(8'h50, 8'hFF, 3'd2);
        check(m_r9 == 16'h0000, "R3 1000 half refused", m_r9, 0);
        check(m_m32 == 16'h0000, "R4 2.5G half refused", m_m32, 0);
        check(m_r4 == 16'h0800, "R6 transmit-only pause", m_r4, 16'h0800);
    endtask

    task automatic t_fast_rx();
        setup(16'h0000, 16'h0000, 16'h0000, 16'h0000, -1, 2);
        run(8'hA0, 8'hFF, 3'd1);
        check(m_r9 == 16'h0200, "R3 1000 full", m_r9, 16'h0200);
        check(m_m32 == 16'h0080, "R4 2.5G full", m_m32, 16'h0080);
        check(m_r4 == 16'h0C00, "R6 receive pause", m_r4, 16'h0C00);
    endtask

    task automatic t_fallback();
        setup(16'h0000, 16'h0C00, 16'h0000, 16'h1234, -1, 2);
        run(8'h00, 8'h2F, 3'd0);
        check(m_r4 == 16'h01E0, "R5 zero request uses cap, R6 none", m_r4, 16'h01E0);
        check(m_r9 == 16'h0200, "R5 fallback gigabit", m_r9, 16'h0200);
        check(m_m32 == 16'h1234 && n_m32 == 0, "R8 mmd untouched", n_m32, 0);
    endtask

    task automatic t_and_mask();
        setup(16'h0000, 16'h0000, 16'h5555, 16'h0000, -1, 2);
        run(8'h0A, 8'h03, 3'd0);
        check(m_r4 == 16'h0040, "R5 request and cap", m_r4, 16'h0040);
        check(n_r9 == 0 && n_m32 == 0, "R8 gated registers untouched", n_r9 + n_m32, 0);
    endtask

    task automatic t_bad_mode();
        setup(16'h0000, 16'h0000, 16'h0000, 16'h0000, -1, 2);
        run(8'h0F, 8'hFF, 3'd5);
        check(status == 2'b01, "R7 config error", status, 1);
        check(n_acc == 0, "R7 no access", n_acc, 0);
    endtask

    task automatic t_timeout();
        setup(16'h0000, 16'h0000, 16'h0000, 16'h0000, -1, 1000);
        run(8'h01, 8'h0F, 3'd0);
        check(status == 2'b00 && !an_complete, "R11 exhausted not an error", {status, an_complete}, 0);
        check(n_r1 == 8, "R11 R10 status reads over four polls", n_r1, 8);
    endtask

    task automatic t_access_error();
        setup(16'h0000, 16'h1111, 16'h0000, 16'h0000, 2, 2);
        run(8'h0F, 8'hFF, 3'd3);
        check(status == 2'b10, "R12 access error status", status, 2);
        repeat (6) @(negedge clk);
        check(n_acc == 3 && !acc_req, "R12 no access after error", n_acc, 3);
        check(m_r4 == 16'h1111, "R12 reg4 not written", m_r4, 16'h1111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_legacy_full_fc();
        t_half_refused();
        t_fast_rx();
        t_fallback();
        t_and_mask();
        t_bad_mode();
        t_timeout();
        t_access_error();
        finish_run();
    end

    initial begin
        #400000;
        checks++; fails++;
        $display("FAIL watchdog: global timeout, actual %0d expected <50000 cycles", cycles);
        finish_run();
    end
endmodule